// File: doc/BRIEF.md
# Two-Stage OFDM Bit Interleaver

This block reorders the coded bits of one OFDM symbol before they reach the constellation mapper. Bits arrive one per valid cycle. Each input position k is sent through two index maps. The first spreads consecutive bits across 16 columns. The second rotates bits inside groups of s positions, where s depends on the bits carried per subcarrier. The bit is stored at the final position, and the finished symbol is then played out in address order.

Storage is two banks of single-bit memory used as a ping-pong pair. One symbol is written into one bank while the previous symbol is read from the other, so the input and output streams can both run without gaps. The symbol size is picked per symbol from four settings. A size request can arrive at any time, but it is held until the next symbol boundary. When the size shrinks, the sender must leave at least the old symbol length of idle cycles before feeding the smaller symbol. Otherwise the writer would catch up with the reader that is still draining the larger bank.

Top module: `ofdm_bit_interleaver`

## Requirements
- R1: After reset, `out_vld` and `out_last` are low and stay low until a full symbol has been written.
- R2: For size codes 0 (N=48) and 1 (N=96), the group size s is 1. Input bit k appears at output position i = (N/16)*(k mod 16) + floor(k/16) of its symbol.
- R3: For size code 2 (N=192), s = 2. Input bit k appears at output position j = s*floor(i/s) + (i + N - floor(16*i/N)) mod s, with i as in R2.
- R4: For size code 3 (N=288), s = 3. Positions follow the same formula as R3.
- R5: The first output bit of a symbol is presented two clock cycles after the cycle in which the symbol's last input bit was accepted.
- R6: Each symbol produces exactly N output bits on consecutive cycles. `out_last` is high only with the final one.
- R7: A size request made with `size_chg` in the middle of a symbol does not alter that symbol. It applies from the next symbol on.
- R8: `start` accepted with a valid bit makes that bit index 0 of a new symbol. Any partially written symbol is discarded and produces no output.
- R9: Symbols fed back to back with non-decreasing size come out back to back, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Realign: current valid bit is index 0 of a new symbol |
| in_vld | input | 1 | Input bit valid |
| in_bit | input | 1 | Serial coded bit |
| size_chg | input | 1 | Strobe that requests the size in `size_in` |
| size_in | input | 2 | Size code: 0=48, 1=96, 2=192, 3=288 bits |
| out_vld | output | 1 | Output bit valid |
| out_bit | output | 1 | Serial interleaved bit |
| out_last | output | 1 | Marks the last output bit of a symbol |

## Verification
Random symbols are sent at every size, two per size, back to back. This separates the identity second stage (sizes 48 and 96) from the pair swap (192) and the three-way rotation (288). It also exposes any bank hand-off bubble between symbols. A size request is raised part way through a 96-bit symbol, and the following symbol must come out at 288 bits. A 20-bit fragment is cut short by `start`, which shows whether stale bits leak out. Output latency is measured for each symbol against its last input cycle.

// File: rtl/ofdm_bit_interleaver.sv
module ofdm_bit_interleaver #(
  parameter int AW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_vld,
  input  logic       in_bit,
  input  logic       size_chg,
  input  logic [1:0] size_in,
  output logic       out_vld,
  output logic       out_bit,
  output logic       out_last
);
  localparam int DEPTH = 1 << (AW - 1);

  function automatic logic [AW-1:0] blk_len(input logic [1:0] c);
    case (c)
      2'd0: return AW'(48);
      2'd1: return AW'(96);
      2'd2: return AW'(192);
      default: return AW'(288);
    endcase
  endfunction

  logic          mem [2][DEPTH];
  logic [AW-1:0] wcnt, kk, wn, cols, ii, fl, tt, jj;
  logic [AW-1:0] rcnt, rn;
  logic [1:0]    cur_sel, pend_sel, wsel;
  logic          pend_v, wbank, rbank, rbusy, done;

  assign kk   = start ? '0 : wcnt;
  assign wsel = (kk == '0 && pend_v) ? pend_sel : cur_sel;
  assign wn   = blk_len(wsel);
  assign cols = wn >> 4;
  assign ii   = AW'(kk[3:0]) * cols + AW'(kk[AW-1:4]);
  assign tt   = ii + wn - fl;
  assign done = in_vld && (kk == wn - AW'(1));

  always_comb begin
    case (wsel)
      2'd0: fl = ii / AW'(3);
      2'd1: fl = ii / AW'(6);
      2'd2: fl = ii / AW'(12);
      default: fl = ii / AW'(18);
    endcase
    case (wsel)
      2'd2:    jj = {ii[AW-1:1], 1'b0} + (tt % AW'(2));
      2'd3:    jj = (ii / AW'(3)) * AW'(3) + (tt % AW'(3));
      default: jj = ii;
    endcase
  end

  always_ff @(posedge clk)
    if (in_vld) mem[wbank][jj[AW-2:0]] <= in_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0; wbank <= 1'b0;
      cur_sel <= 2'd0; pend_sel <= 2'd0; pend_v <= 1'b0;
      rbusy <= 1'b0; rbank <= 1'b0; rcnt <= '0; rn <= '0;
      out_vld <= 1'b0; out_bit <= 1'b0; out_last <= 1'b0;
    end else begin
      if (size_chg) begin
        pend_v <= 1'b1; pend_sel <= size_in;
      end else if (pend_v && kk == '0) begin
        cur_sel <= pend_sel; pend_v <= 1'b0;
      end

      if (in_vld) begin
        if (done) begin
          wcnt <= '0; wbank <= ~wbank;
        end else begin
          wcnt <= kk + AW'(1);
        end
      end else if (start) begin
        wcnt <= '0;
      end

      if (done) begin
        rbusy <= 1'b1; rbank <= wbank; rcnt <= '0; rn <= wn;
      end else if (rbusy) begin
        if (rcnt == rn - AW'(1)) rbusy <= 1'b0;
        rcnt <= rcnt + AW'(1);
      end

      out_vld  <= rbusy;
      out_bit  <= mem[rbank][rcnt[AW-2:0]];
      out_last <= rbusy && (rcnt == rn - AW'(1));
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rbusy |=> !out_last);
  p_read_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rbusy |-> (rcnt < rn));
  p_write_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt < blk_len(cur_sel));
  p_size_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != '0 && !start) |=> $stable(cur_sel));
  p_last_with_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_vld);
  p_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_last) |=> out_vld);
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ##2 out_vld);
endmodule

// File: tb/sim_ofdm_bit_interleaver.sv
module sim_ofdm_bit_interleaver;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_vld = 1'b0, in_bit = 1'b0, size_chg = 1'b0;
  logic [1:0] size_in = 2'd0;
  logic out_vld, out_bit, out_last;

  ofdm_bit_interleaver u0 (.clk, .rst_n, .start, .in_vld, .in_bit, .size_chg,
                           .size_in, .out_vld, .out_bit, .out_last);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit exp_b [0:4095];
  bit exp_l [0:4095];
  string exp_tag [0:4095];
  int blk_first [0:63];
  int blk_cyc [0:63];
  int ei = 0, oi = 0, nb = 0, bk = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int len_of(input int c);
    return (c == 0) ? 48 : (c == 1) ? 96 : (c == 2) ? 192 : 288;
  endfunction

  function automatic int perm(input int n, input int k);
    int s, i;
    s = (n == 192) ? 2 : (n == 288) ? 3 : 1;
    i = (n / 16) * (k % 16) + k / 16;
    return s * (i / s) + (i + n - (16 * i) / n) % s;
  endfunction

  task automatic idle(input int c);
    repeat (c) begin
      @(negedge clk);
      in_vld = 0; start = 0; size_chg = 0;
    end
  endtask

  task automatic set_size(input logic [1:0] v);
    @(negedge clk); in_vld = 0; start = 0; size_chg = 1; size_in = v;
    @(negedge clk); size_chg = 0;
  endtask

  task automatic send_block(input int c, input bit st, input int chg_at,
                            input logic [1:0] chg_v, input string tag);
    bit b [0:287];
    int n;
    n = len_of(c);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      b[k] = 1'($urandom);
      in_vld = 1; in_bit = b[k]; start = st && (k == 0);
      size_chg = (k == chg_at); size_in = chg_v;
    end
    for (int k = 0; k < n; k++) begin
      exp_b[ei + perm(n, k)] = b[k];
      exp_l[ei + k] = (k == n - 1);
      exp_tag[ei + k] = tag;
    end
    blk_first[nb] = ei; blk_cyc[nb] = cyc; nb++;
    ei += n;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      chk(0, "watchdog", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (oi >= ei) begin
        chk(0, "R8 unexpected output bit", oi, ei);
      end else begin
        chk(out_bit == exp_b[oi], exp_tag[oi], int'(out_bit), int'(exp_b[oi]));
        chk(out_last == exp_l[oi], "R6 last flag", int'(out_last), int'(exp_l[oi]));
        if (bk < nb && oi == blk_first[bk]) begin
          chk(cyc == blk_cyc[bk] + 2, "R5 latency", cyc - blk_cyc[bk], 2);
          bk++;
        end
        oi++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_vld == 0 && out_last == 0, "R1 reset outputs", int'(out_vld), 0);
    rst_n = 1;
    idle(5);
    chk(out_vld == 0, "R1 idle after reset", int'(out_vld), 0);

    set_size(2'd0); idle(2);
    send_block(0, 0, -1, 2'd0, "R2 N=48");
    send_block(0, 0, -1, 2'd0, "R9 N=48 back to back");
    idle(10);
    set_size(2'd1); idle(2);
    send_block(1, 0, -1, 2'd1, "R2 N=96");
    send_block(1, 0, -1, 2'd1, "R9 N=96 back to back");
    idle(10);
    set_size(2'd2); idle(2);
    send_block(2, 0, -1, 2'd2, "R3 N=192");
    send_block(2, 0, -1, 2'd2, "R3 N=192 second");
    idle(10);
    set_size(2'd3); idle(2);
    send_block(3, 0, -1, 2'd3, "R4 N=288");
    send_block(3, 0, -1, 2'd3, "R4 N=288 second");
    idle(300);

    set_size(2'd1); idle(2);
    send_block(1, 0, 40, 2'd3, "R7 size held mid-symbol");
    send_block(3, 0, -1, 2'd3, "R7 new size next symbol");
    idle(300);

    set_size(2'd2); idle(2);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      in_vld = 1; in_bit = 1'($urandom); start = (k == 0); size_chg = 0;
    end
    send_block(2, 1, -1, 2'd2, "R8 start realigns");
    idle(300);

    set_size(2'd0); idle(2);
    send_block(0, 1, -1, 2'd0, "R9 run a");
    send_block(0, 0, -1, 2'd0, "R9 run b");
    send_block(0, 0, -1, 2'd0, "R9 run c");
    idle(100);

    chk(oi == ei, "R6 all bits emitted", oi, ei);
    chk(bk == nb, "R5 every symbol timed", bk, nb);
    chk(out_vld == 0, "R6 quiet when drained", int'(out_vld), 0);
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule